// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array Model

This block is a synthesizable behavioural model of a dynamic memory array with a shared address bus. A word is located in two phases. In the row phase the full address bus is captured when the active-low row strobe falls. In the column phase the low bits of the bus are captured when the active-low column strobe falls. Both strobes are sampled on the system clock, and a strobe "falls" on the clock edge where it is first sampled low after being sampled high.

The data port is modelled as three signals: an input word, an output word and an output-enable flag. An upper level turns these into tri-state pins. The active-low write input sets the direction of the port. The active-low output enable, the column strobe and the row strobe together decide whether the port is driven. A row-strobe-only cycle acts as a refresh: it touches no stored data and never drives the port.

With `COL_W = 6` the array holds 16K words of 4 bits. The default `COL_W = 2` keeps the array small when the model is elaborated on its own. A column strobe fall is accepted only if it comes at least one clock after the row strobe fall that opened the row.

Top module: `mux_dram`

## Requirements
- R1: While reset is held, and right after it, `dq_oe` is 0 and `dq_out` is 0.
- R2: On a row strobe fall, all `ROW_W` bits of `addr` are captured as the row. Changes on `addr` while the row strobe stays low do not alter the captured row.
- R3: On a valid column strobe fall, the low `COL_W` bits of `addr` are taken as the column, and the upper bits are ignored. The word index is {row, column}, with the row in the upper bits.
- R4: A valid column strobe fall with `we_n` low stores `dq_in` at the indexed word. `dq_oe` stays 0 throughout the write cycle.
- R5: A valid column strobe fall with `we_n` high reads the indexed word. From that edge, `dq_out` carries the word and `dq_oe` is 1 while `oe_n` is low.
- R6: While `oe_n` is high, `dq_oe` is 0. If `oe_n` returns low within the same read cycle, the same word is driven again.
- R7: While the column strobe is high, `dq_oe` is 0.
- R8: While `we_n` is low, `dq_oe` is 0, because the port acts as an input. If `we_n` returns high within a read cycle, the read word is driven again.
- R9: A row-strobe-only cycle, with the column strobe kept high, changes no stored word and keeps `dq_oe` at 0.
- R10: While both strobes stay low, `oe_n` is low and `we_n` is high, `dq_out` holds the read word, even if `addr` or `dq_in` change.
- R11: A column strobe fall while the row strobe is high is ignored. It causes no write and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write; high selects output direction |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ROW_W | Shared row/column address bus |
| dq_in | input | DW | Data arriving from the pins |
| dq_out | output | DW | Data to drive onto the pins |
| dq_oe | output | 1 | Pin driver enable |

## Verification
Random writes and reads over random rows and columns are compared with a word model kept in the bench. Wrong indexing, lost writes and stale read data all show up as mismatches. Directed cycles cover the following cases:
- The address bus changes after the row is captured, which separates correct row capture from transparent latching.
- Different upper bits are placed on the bus during the column phase, which exposes a wrong column width.
- Output enable, column strobe and write are toggled in the middle of a read, which separates each gating condition from the others.
- Refresh cycles and column-only strobes are issued over known data, which shows that neither one writes or drives.

// File: rtl/mux_dram.sv
module mux_dram #(
  parameter int ROW_W = 8,
  parameter int COL_W = 2,
  parameter int DW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic             ras_q, cas_q, row_open, col_rd;
  logic [ROW_W-1:0] row_r;
  logic [DW-1:0]    rd_q;

  wire             ras_fall = ras_q & ~ras_n;
  wire             cas_fall = cas_q & ~cas_n & ~ras_n & row_open;
  wire [IDX_W-1:0] idx      = {row_r, addr[COL_W-1:0]};
  wire             wr_go    = cas_fall & ~we_n;
  wire             rd_go    = cas_fall & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      row_open <= 1'b0;
      col_rd   <= 1'b0;
      row_r    <= '0;
      rd_q     <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_n)         row_open <= 1'b0;
      else if (ras_fall) row_open <= 1'b1;
      if (ras_fall) row_r <= addr;
      if (cas_n)      col_rd <= 1'b0;
      else if (rd_go) col_rd <= 1'b1;
      else if (wr_go) col_rd <= 1'b0;
      if (rd_go) rd_q <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[idx] <= dq_in;
  end

  assign dq_out = rd_q;
  assign dq_oe  = col_rd & ~cas_n & ~ras_n & ~oe_n & we_n;

  // R2
  row_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_fall) |-> row_r == $past(addr));

  // R4
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_go) |-> mem[$past(idx)] == $past(dq_in));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && $past(dq_oe) |-> $stable(dq_out));

  // R11
  drive_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> row_open);
endmodule

// File: tb/mux_dram_test.sv
module mux_dram_test;
  localparam int ROW_W = 8;
  localparam int COL_W = 2;
  localparam int DW    = 4;
  localparam int DEPTH = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ROW_W-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int compared = 0;
  int mismatched = 0;
  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];

  always #2.5 clk = ~clk;

  mux_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic int idx_of(logic [ROW_W-1:0] r, logic [ROW_W-1:0] c);
    return int'({r, c[COL_W-1:0]});
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic open_row(logic [ROW_W-1:0] r);
    ras_n = 1'b1; cas_n = 1'b1; addr = r;
    step();
    ras_n = 1'b0;
    step();
  endtask

  task automatic close_all();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step();
  endtask

  task automatic do_write(logic [ROW_W-1:0] r, logic [ROW_W-1:0] c, logic [DW-1:0] d);
    open_row(r);
    addr = c; we_n = 1'b0; dq_in = d; cas_n = 1'b0;
    step();
    check("R4 no drive during write", dq_oe, 0);
    dq_in = DW'($urandom);
    close_all();
    model[idx_of(r, c)] = d;
    known[idx_of(r, c)] = 1'b1;
  endtask

  task automatic start_read(logic [ROW_W-1:0] r, logic [ROW_W-1:0] c);
    open_row(r);
    addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
    step();
  endtask

  task automatic do_read(string req, logic [ROW_W-1:0] r, logic [ROW_W-1:0] c);
    start_read(r, c);
    check(req, dq_oe, 1);
    check(req, int'(dq_out), int'(model[idx_of(r, c)]));
    close_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) step();
    // R1
    check("R1 oe in reset", dq_oe, 0);
    rst_n = 1'b1;
    step();
    check("R1 oe after reset", dq_oe, 0);
    check("R1 out after reset", int'(dq_out), 0);

    // R4 R5 basic
    do_write(8'h00, 8'h00, 4'h5);
    do_read("R5 read 5", 8'h00, 8'h00);
    do_write(8'hFF, 8'h03, 4'hA);
    do_read("R5 read A", 8'hFF, 8'h03);

    // R2: address moves after row fall, before column
    do_write(8'h3C, 8'h01, 4'h9);
    do_write(8'hC3, 8'h01, 4'h6);
    open_row(8'h3C);
    addr = 8'hC3;
    step();
    addr = 8'h01; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
    step();
    check("R2 row held", int'(dq_out), 9);
    close_all();

    // R3: upper column bits ignored
    do_write(8'h12, 8'hF6, 4'h3);
    do_read("R3 alias column", 8'h12, 8'h02);
    do_read("R3 other column untouched", 8'h12, 8'h01);

    // R6 R7 R8 R10 within one read
    do_write(8'h55, 8'h02, 4'hC);
    start_read(8'h55, 8'h02);
    check("R5 drive", dq_oe, 1);
    oe_n = 1'b1; step();
    check("R6 oe high", dq_oe, 0);
    oe_n = 1'b0; step();
    check("R6 redrive", dq_oe, 1);
    check("R6 same word", int'(dq_out), 12);
    we_n = 1'b0; step();
    check("R8 write low", dq_oe, 0);
    we_n = 1'b1; step();
    check("R8 redrive", dq_oe, 1);
    for (int k = 0; k < 4; k++) begin
      addr = ROW_W'($urandom); dq_in = DW'($urandom);
      step();
      check("R10 hold", int'(dq_out), 12);
      check("R10 drive", dq_oe, 1);
    end
    cas_n = 1'b1; step();
    check("R7 column high", dq_oe, 0);
    close_all();

    // R9 refresh
    for (int k = 0; k < 10; k++) begin
      addr = 8'h55; ras_n = 1'b0; dq_in = 4'h1;
      step();
      check("R9 no drive", dq_oe, 0);
      ras_n = 1'b1; step();
    end
    do_read("R9 data kept", 8'h55, 8'h02);

    // R11 column fall with row high
    do_write(8'h77, 8'h00, 4'h4);
    ras_n = 1'b1; addr = 8'h00; we_n = 1'b0; dq_in = 4'hB; cas_n = 1'b0;
    step();
    check("R11 no drive", dq_oe, 0);
    close_all();
    do_read("R11 no write", 8'h77, 8'h00);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [ROW_W-1:0] r, c;
      r = ROW_W'($urandom);
      c = ROW_W'($urandom);
      if (($urandom % 2) == 0 || !known[idx_of(r, c)])
        do_write(r, c, DW'($urandom));
      else
        do_read("R5 random read", r, c);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule